// File: doc/BRIEF.md
# Three-Set Instruction Cache Fill Controller

This block sits between the instruction fetch stage and main memory. It keeps three cache sets (Z, 0 and 1), each switched on or off by its own enable bit. Each set holds a tag, a valid bit and eight 32-bit words per line. When the processor presents a PC reference, the block looks it up in every enabled set within the same cycle. On a hit it raises the ready signal, and the fetch stage loads the word on the next clock edge. On a miss the ready signal stays low. That stalls the processor clocks until the block has fetched data from memory.

The enable pattern and whether the address lies inside a configured set Z window decide how a miss is handled. A fill either makes one 64-bit memory read that does not leave the line valid, or it makes a four-beat burst that loads a whole line and marks its tag valid. When both set 0 and set 1 are eligible, a free-running LFSR picks which of the two receives the line. The word that was asked for is captured as its beat arrives. It is handed to the fetch stage in the cycle after the last memory beat.

Top module: `icfill_ctrl`

## Requirements
- R1: After reset every valid bit is clear, `mem_req` and `icd_valid` are low, and a lookup in any set misses.
- R2: A reference that hits a valid line with a matching tag in an enabled set raises `icd_valid` in the same cycle, with that word on `icd_data`, and issues no memory request.
- R3: A line held in a set whose enable bit is low does not count as a hit. `set_en` bit 0 enables set Z, bit 1 enables set 0 and bit 2 enables set 1.
- R4: On a miss, `icd_valid` stays low and `mem_req` rises at the next clock edge. `icd_valid` stays low for as long as `mem_req` is high.
- R5: A burst fill makes four 64-bit reads at word addresses line base +0, +2, +4 and +6, in that order. Each address is held until `mem_ack`, and every address is even. The low half of `mem_rdata` is the even word.
- R6: In the cycle after the last acknowledged beat, `icd_valid` is high for one cycle and carries the requested word. After a burst, the other words of the line hit.
- R7: With no set enabled, a miss makes one read at the double-word address of the PC and delivers the requested word. The set Z slot for that address is left invalid, so enabling set Z afterwards still misses there.
- R8: With only set Z enabled, an address inside the set Z window (Z_BASE up to Z_BASE + Z_LINES*8 words) is filled into set Z by a burst and then hits.
- R9: With only set Z enabled, an address outside the window gets a single read, and its line is left invalid, so a repeat reference reads memory again.
- R10: With exactly one of set 0 and set 1 enabled, a miss that set Z does not take is burst-filled into that enabled set. This includes a window address while set Z is disabled.
- R11: With set 0 and set 1 both enabled, a non-window miss is burst-filled into exactly one of them.
- R12: With all sets enabled, a window address is filled into set Z and into neither set 0 nor set 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_en | input | 3 | Set enables: bit 0 set Z, bit 1 set 0, bit 2 set 1 |
| pc_req | input | 1 | PC reference present, held until `icd_valid` |
| pc_addr | input | ADDR_W | Word address of the reference |
| icd_valid | output | 1 | Instruction word ready; processor clocks run |
| icd_data | output | WORD_W | Instruction word |
| mem_req | output | 1 | Memory double-word read request |
| mem_addr | output | ADDR_W | Even word address of the double word |
| mem_ack | input | 1 | Memory beat acknowledge, data valid |
| mem_rdata | input | 2*WORD_W | Double word, even word in the low half |

## Verification
A hit is visible in the cycle of the reference itself, because the lookup is combinational. A miss raises `mem_req` one edge later. Each beat is taken at the edge where `mem_ack` is high, and `icd_valid` returns exactly one edge after the final beat. The bench drives inputs on the falling edge and samples 1 ns later. For a reference it checks `icd_valid` before any rising edge has passed. It then polls at successive falling edges until the word is ready and compares the number of memory beats with the number the policy requires. Set membership is probed by presenting a reference and withdrawing it within the low clock phase, so a probe never starts a fill.

// File: rtl/icf_pkg.sv
package icf_pkg;

   localparam int unsigned NUM_SETS = 3;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_DONE = 2'd2
   } icf_state_e;

   typedef enum logic [1:0] {
      TGT_Z  = 2'd0,
      TGT_S0 = 2'd1,
      TGT_S1 = 2'd2
   } icf_tgt_e;

   typedef struct packed {
      icf_tgt_e tgt;
      logic     burst;
   } icf_plan_t;

endpackage

// File: rtl/icf_lfsr.sv
module icf_lfsr #(
   parameter int unsigned W    = 4,
   parameter logic [W-1:0] TAPS = 4'b1100
) (
   input  logic         clk,
   input  logic         rst_n,
   output logic [W-1:0] q
);

   if (W < 2) begin : g_bad_w
      $error("icf_lfsr: W must be at least 2");
   end

   logic fb;
   assign fb = ^(q & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n) q <= W'(1);
      else        q <= {q[W-2:0], fb};
   end

endmodule

// File: rtl/icf_policy.sv
module icf_policy
   import icf_pkg::*;
(
   input  logic [NUM_SETS-1:0] set_en,
   input  logic                in_zone,
   input  logic                coin,
   output icf_plan_t           plan
);

   logic z_on, a_on, b_on;
   assign z_on = set_en[0];
   assign a_on = set_en[1];
   assign b_on = set_en[2];

   always_comb begin
      plan.tgt   = TGT_Z;
      plan.burst = 1'b0;
      if (z_on && in_zone) begin
         plan.tgt   = TGT_Z;
         plan.burst = 1'b1;
      end else if (a_on && b_on) begin
         plan.tgt   = coin ? TGT_S1 : TGT_S0;
         plan.burst = 1'b1;
      end else if (a_on) begin
         plan.tgt   = TGT_S0;
         plan.burst = 1'b1;
      end else if (b_on) begin
         plan.tgt   = TGT_S1;
         plan.burst = 1'b1;
      end else begin
         plan.tgt   = TGT_Z;
         plan.burst = 1'b0;
      end
   end

endmodule

// File: rtl/icf_way.sv
module icf_way #(
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned OFF_W  = 3,
   parameter int unsigned TAG_W  = 9,
   parameter int unsigned WORD_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    rd_idx,
   input  logic [OFF_W-1:0]    rd_off,
   input  logic [TAG_W-1:0]    rd_tag,
   output logic                rd_hit,
   output logic [WORD_W-1:0]   rd_word,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [OFF_W-2:0]    wr_dw,
   input  logic [2*WORD_W-1:0] wr_data,
   input  logic                inv_en,
   input  logic [IDX_W-1:0]    inv_idx,
   input  logic                mark_en,
   input  logic [TAG_W-1:0]    mark_tag
);

   localparam int unsigned LINES = 1 << IDX_W;
   localparam int unsigned WORDS = 1 << OFF_W;
   localparam int unsigned DEPTH = LINES * WORDS;
   localparam int unsigned AW    = IDX_W + OFF_W;

   logic [LINES-1:0]  vld_q;
   logic [TAG_W-1:0]  tag_q [LINES];
   logic [WORD_W-1:0] dat_q [DEPTH];

   logic [AW-1:0] rd_ptr;
   logic [AW-1:0] wr_lo;
   logic [AW-1:0] wr_hi;

   assign rd_ptr  = {rd_idx, rd_off};
   assign wr_lo   = {wr_idx, wr_dw, 1'b0};
   assign wr_hi   = {wr_idx, wr_dw, 1'b1};
   assign rd_hit  = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
   assign rd_word = dat_q[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         if (inv_en)  vld_q[inv_idx] <= 1'b0;
         if (mark_en) vld_q[wr_idx]  <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (mark_en) tag_q[wr_idx] <= mark_tag;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         dat_q[wr_lo] <= wr_data[WORD_W-1:0];
         dat_q[wr_hi] <= wr_data[2*WORD_W-1:WORD_W];
      end
   end

endmodule

// File: rtl/icfill_ctrl.sv
module icfill_ctrl
   import icf_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned WORD_W     = 32,
   parameter int unsigned IDX_W      = 4,
   parameter int unsigned LINE_WORDS = 8,
   parameter int unsigned Z_BASE     = 16'h0400,
   parameter int unsigned Z_LINES    = 16,
   parameter int unsigned LFSR_W     = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2:0]          set_en,
   input  logic                pc_req,
   input  logic [ADDR_W-1:0]   pc_addr,
   output logic                icd_valid,
   output logic [WORD_W-1:0]   icd_data,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic                mem_ack,
   input  logic [2*WORD_W-1:0] mem_rdata
);

   localparam int unsigned OFF_W  = $clog2(LINE_WORDS);
   localparam int unsigned BEAT_W = OFF_W - 1;
   localparam int unsigned BEATS  = LINE_WORDS / 2;
   localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
   localparam logic [ADDR_W:0] ZLO = (ADDR_W+1)'(Z_BASE);
   localparam logic [ADDR_W:0] ZHI = (ADDR_W+1)'(Z_BASE + Z_LINES * LINE_WORDS);

   if ((1 << OFF_W) != LINE_WORDS || LINE_WORDS < 4) begin : g_bad_line
      $error("icfill_ctrl: LINE_WORDS must be a power of two of at least 4");
   end
   if (ADDR_W <= IDX_W + OFF_W) begin : g_bad_addr
      $error("icfill_ctrl: ADDR_W leaves no tag bits");
   end
   if ((Z_BASE % LINE_WORDS) != 0) begin : g_bad_zbase
      $error("icfill_ctrl: Z_BASE must be line aligned");
   end
   if (Z_BASE + Z_LINES * LINE_WORDS > (1 << ADDR_W)) begin : g_bad_zsize
      $error("icfill_ctrl: set Z window exceeds address space");
   end
   if (LFSR_W < 2) begin : g_bad_lfsr
      $error("icfill_ctrl: LFSR_W must be at least 2");
   end

   // ---------------- lookup address split ----------------
   logic [TAG_W-1:0] pc_tag;
   logic [IDX_W-1:0] pc_idx;
   logic [OFF_W-1:0] pc_off;
   logic             in_zone;

   assign pc_tag  = pc_addr[ADDR_W-1 -: TAG_W];
   assign pc_idx  = pc_addr[OFF_W +: IDX_W];
   assign pc_off  = pc_addr[OFF_W-1:0];
   assign in_zone = ({1'b0, pc_addr} >= ZLO) && ({1'b0, pc_addr} < ZHI);

   // ---------------- victim choice ----------------
   logic [LFSR_W-1:0] rnd_q;
   icf_plan_t         plan;

   icf_lfsr #(
      .W    (LFSR_W),
      .TAPS (LFSR_W'(2'b11) << (LFSR_W - 2))
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .q     (rnd_q)
   );

   icf_policy u_policy (
      .set_en  (set_en),
      .in_zone (in_zone),
      .coin    (rnd_q[0]),
      .plan    (plan)
   );

   // ---------------- fill state ----------------
   icf_state_e        state_q;
   icf_tgt_e          tgt_q;
   logic              burst_q;
   logic [BEAT_W-1:0] beat_q;
   logic [ADDR_W-1:0] fill_addr_q;
   logic [WORD_W-1:0] word_q;

   logic              hit_any;
   logic              miss_go;
   logic              fill_ack;
   logic              last_beat;
   logic [BEAT_W-1:0] wr_dw;
   logic [TAG_W-1:0]  fill_tag;
   logic [IDX_W-1:0]  fill_idx;

   assign fill_tag  = fill_addr_q[ADDR_W-1 -: TAG_W];
   assign fill_idx  = fill_addr_q[OFF_W +: IDX_W];
   assign miss_go   = (state_q == ST_IDLE) && pc_req && !hit_any;
   assign fill_ack  = (state_q == ST_FILL) && mem_ack;
   assign last_beat = !burst_q || (beat_q == BEAT_W'(BEATS - 1));
   assign wr_dw     = burst_q ? beat_q : fill_addr_q[OFF_W-1:1];

   // ---------------- the three sets ----------------
   logic [NUM_SETS-1:0] way_hit;
   logic [NUM_SETS-1:0] hit_en;
   logic [WORD_W-1:0]   way_word [NUM_SETS];

   for (genvar g = 0; g < NUM_SETS; g++) begin : g_way
      logic to_me;
      logic plan_me;
      assign to_me   = (tgt_q == icf_tgt_e'(g));
      assign plan_me = (plan.tgt == icf_tgt_e'(g));

      icf_way #(
         .IDX_W  (IDX_W),
         .OFF_W  (OFF_W),
         .TAG_W  (TAG_W),
         .WORD_W (WORD_W)
      ) u_way (
         .clk      (clk),
         .rst_n    (rst_n),
         .rd_idx   (pc_idx),
         .rd_off   (pc_off),
         .rd_tag   (pc_tag),
         .rd_hit   (way_hit[g]),
         .rd_word  (way_word[g]),
         .wr_en    (fill_ack && to_me),
         .wr_idx   (fill_idx),
         .wr_dw    (wr_dw),
         .wr_data  (mem_rdata),
         .inv_en   (miss_go && plan_me),
         .inv_idx  (pc_idx),
         .mark_en  (fill_ack && last_beat && burst_q && to_me),
         .mark_tag (fill_tag)
      );
   end

   assign hit_en  = way_hit & set_en;
   assign hit_any = |hit_en;

   logic [WORD_W-1:0] hit_word;
   always_comb begin
      hit_word = '0;
      for (int i = NUM_SETS - 1; i >= 0; i--) begin
         if (hit_en[i]) hit_word = way_word[i];
      end
   end

   // ---------------- controller ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         tgt_q       <= TGT_Z;
         burst_q     <= 1'b0;
         beat_q      <= '0;
         fill_addr_q <= '0;
         word_q      <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (miss_go) begin
                  state_q     <= ST_FILL;
                  tgt_q       <= plan.tgt;
                  burst_q     <= plan.burst;
                  beat_q      <= '0;
                  fill_addr_q <= pc_addr;
               end
            end
            ST_FILL: begin
               if (mem_ack) begin
                  if (wr_dw == fill_addr_q[OFF_W-1:1]) begin
                     word_q <= fill_addr_q[0] ? mem_rdata[2*WORD_W-1:WORD_W]
                                              : mem_rdata[WORD_W-1:0];
                  end
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) state_q <= ST_DONE;
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = (state_q == ST_FILL);
   assign mem_addr  = burst_q ? {fill_addr_q[ADDR_W-1:OFF_W], beat_q, 1'b0}
                              : {fill_addr_q[ADDR_W-1:1], 1'b0};
   assign icd_valid = (state_q == ST_DONE) || ((state_q == ST_IDLE) && pc_req && hit_any);
   assign icd_data  = (state_q == ST_DONE) ? word_q : hit_word;

endmodule

// File: rtl/icfill_ctrl_chk.sv
module icfill_ctrl_chk #(
   parameter int unsigned ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pc_req,
   input logic              icd_valid,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack
);

   AST_NO_VALID_DURING_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !icd_valid);                                         // R4

   AST_MISS_STARTS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_req && !icd_valid && !mem_req) |=> mem_req);                 // R4

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));       // R5

   AST_ADDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !mem_addr[0]);                                       // R5

   AST_READY_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_req) |-> icd_valid);                                   // R6

   AST_HIT_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_req && icd_valid) |=> !mem_req);                             // R2

endmodule

bind icfill_ctrl icfill_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pc_req    (pc_req),
   .icd_valid (icd_valid),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack)
);

// File: tb/icfill_ctrl_bench.sv
`timescale 1ns/1ps
module icfill_ctrl_bench;

   localparam int unsigned AW = 16;
   localparam int unsigned WW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    set_en = 3'b000;
   logic          pc_req = 1'b0;
   logic [AW-1:0] pc_addr = '0;
   logic          icd_valid;
   logic [WW-1:0] icd_data;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic [2*WW-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [AW-1:0] beat_log [16];
   int nlog = 0;
   bit gap = 1'b0;

   always #4 clk = ~clk;

   icfill_ctrl u_icfill_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_en    (set_en),
      .pc_req    (pc_req),
      .pc_addr   (pc_addr),
      .icd_valid (icd_valid),
      .icd_data  (icd_data),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata)
   );

   function automatic logic [WW-1:0] wd(input logic [AW-1:0] a);
      return {16'hD00D, a};
   endfunction

   // memory model: acknowledges every other low phase while requested
   always @(negedge clk) begin
      gap = ~gap;
      if (mem_req && !mem_ack && gap) begin
         mem_ack   = 1'b1;
         mem_rdata = {wd(mem_addr + 16'd1), wd(mem_addr)};
         if (nlog < 16) beat_log[nlog] = mem_addr;
         nlog++;
      end else begin
         mem_ack = 1'b0;
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic fetch(input logic [AW-1:0] a, input logic [2:0] en,
                        input bit exp_hit, input int exp_beats, input string req);
      @(negedge clk);
      set_en = en; pc_addr = a; pc_req = 1'b1; nlog = 0;
      #1;
      check(icd_valid == exp_hit, {req, " ready at request"}, 32'(icd_valid), 32'(exp_hit));
      for (int n = 0; n < 40 && !icd_valid; n++) begin
         @(negedge clk); #1;
         if (!icd_valid && !mem_req)
            check(1'b0, {req, " R4 stall without request"}, 0, 1);
      end
      check(icd_data == wd(a), {req, " word"}, icd_data, wd(a));
      check(nlog == exp_beats, {req, " beats"}, 32'(nlog), 32'(exp_beats));
      @(negedge clk);
      pc_req = 1'b0;
   endtask

   task automatic peek(input logic [AW-1:0] a, input logic [2:0] en, output bit hit);
      @(negedge clk);
      set_en = en; pc_addr = a; pc_req = 1'b1;
      #1 hit = icd_valid;
      #1 pc_req = 1'b0;
   endtask

   task automatic t_reset;
      bit h;
      check(!icd_valid && !mem_req, "R1 outputs idle", {mem_req, icd_valid}, 0);
      peek(16'h0010, 3'b111, h);
      check(!h, "R1 cold lookup misses", 32'(h), 0);
   endtask

   task automatic t_random_pair;
      bit h0, h1, hz;
      fetch(16'h0123, 3'b111, 1'b0, 4, "R11 burst fill");
      check(beat_log[0] == 16'h0120 && beat_log[1] == 16'h0122, "R5 beat order a",
            {beat_log[0], beat_log[1]}, 32'h01200122);
      check(beat_log[2] == 16'h0124 && beat_log[3] == 16'h0126, "R5 beat order b",
            {beat_log[2], beat_log[3]}, 32'h01240126);
      fetch(16'h0125, 3'b111, 1'b1, 0, "R2 R6 line hit");
      peek(16'h0123, 3'b010, h0);
      peek(16'h0123, 3'b100, h1);
      check(h0 != h1, "R11 exactly one of set 0/1", {h0, h1}, 32'h1);
      peek(16'h0123, 3'b001, hz);
      check(!hz, "R3 disabled sets ignored", 32'(hz), 0);
   endtask

   task automatic t_zone_all;
      bit hz, h01;
      fetch(16'h0412, 3'b111, 1'b0, 4, "R12 window fill");
      peek(16'h0417, 3'b001, hz);
      check(hz, "R12 lands in set Z", 32'(hz), 1);
      peek(16'h0417, 3'b110, h01);
      check(!h01, "R12 not in set 0/1", 32'(h01), 0);
   endtask

   task automatic t_z_only;
      bit h;
      fetch(16'h0231, 3'b001, 1'b0, 1, "R9 single read");
      check(beat_log[0] == 16'h0230, "R9 double-word address", beat_log[0], 16'h0230);
      fetch(16'h0231, 3'b001, 1'b0, 1, "R9 repeat still reads");
      fetch(16'h0450, 3'b001, 1'b0, 4, "R8 window burst");
      peek(16'h0453, 3'b001, h);
      check(h, "R8 window hit", 32'(h), 1);
   endtask

   task automatic t_none;
      bit h;
      fetch(16'h0333, 3'b000, 1'b0, 1, "R7 pass-through");
      check(beat_log[0] == 16'h0332, "R7 double-word address", beat_log[0], 16'h0332);
      peek(16'h0333, 3'b001, h);
      check(!h, "R7 slot left invalid", 32'(h), 0);
   endtask

   task automatic t_single;
      bit ha, hb, hz;
      fetch(16'h0500, 3'b010, 1'b0, 4, "R10 set 0 only");
      peek(16'h0506, 3'b010, ha);
      peek(16'h0506, 3'b100, hb);
      check(ha && !hb, "R10 filled set 0", {ha, hb}, 32'h2);
      fetch(16'h0440, 3'b100, 1'b0, 4, "R10 window with Z off");
      peek(16'h0442, 3'b100, hb);
      peek(16'h0442, 3'b001, hz);
      check(hb && !hz, "R10 filled set 1", {hb, hz}, 32'h2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_random_pair();
      t_zone_all();
      t_z_only();
      t_none();
      t_single();
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule